// File: doc/BRIEF.md
# Prioritised vectored interrupt responder

This block gathers interrupt requests from one raster source and three DMA channels and answers the CPU's mode-2 interrupt acknowledge cycles. A request pulse sets a pending flag. Each source also has an enable bit. An active-low request line goes to the CPU whenever an enabled source is pending.

An acknowledge cycle is seen when both the M1 and IORQ strobes are low. At the start of that cycle the block picks the highest-priority pending and enabled source and latches an 8-bit vector for it. The vector is the upper five bits of a programmable base with a three-bit source code below them. The block drives this vector on its data output, with an output enable, for as long as the strobes stay low.

Acknowledging the raster source clears its flag at once and sets a serviced bit in the status register. DMA flags stay set until software clears them. If an acknowledge arrives when nothing eligible is pending, the block returns the DMA channel 0 vector.

Top module: `vec_irq_responder`

## Requirements
- R1: After a synchronous reset all pending flags, enables, the serviced bit and the vector base are zero. `int_n` is high, `dout_oe` is low and `stat_rdata` reads 0x00.
- R2: A one-cycle pulse on `raster_req` or on `dma_req[k]` sets that source's pending flag. DMA channel k's flag reads back in `stat_rdata` bit k (bits 2:0).
- R3: `int_n` is low exactly when some source is both pending and enabled. The enables are status bits 7:4: bit 7 raster, bit 6 DMA 2, bit 5 DMA 1, bit 4 DMA 0. A status write loads all four enable bits.
- R4: An acknowledge starts on the first clock edge at which `m1_n` and `iorq_n` are both low. Only one acknowledge is counted until either strobe returns high. `dout_oe` is high only from that edge until the release, and one strobe low on its own does nothing.
- R5: Among the sources that are pending and enabled, the acknowledge picks raster first, then DMA 2, then DMA 1, then DMA 0.
- R6: The driven vector is the base bits 7:3 followed by a three-bit code: raster 3'b110, DMA 2 3'b000, DMA 1 3'b010, DMA 0 3'b100. Bit 0 is therefore always 0.
- R7: Acknowledging the raster source clears its pending flag in that same acknowledge and sets the serviced bit, status bit 3.
- R8: An acknowledge with no pending and enabled source drives the DMA channel 0 vector. This includes a second acknowledge straight after a raster one.
- R9: An acknowledge does not clear a DMA flag. Writing 1 to status bit k clears DMA k and writing 1 to bit 3 clears the serviced bit. Writing 0 to any of bits 3:0 changes nothing.
- R10: The vector is fixed at the start of the acknowledge. A base write or a new request during the strobe does not change `dout`, and the new request is handled by a later acknowledge.
- R11: If a request pulse and a clearing write to the same flag arrive in the same cycle, the flag ends up set.
- R12: A base write keeps `base_wdata` bits 7:3 and ignores bits 2:0. It takes effect from the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_req | input | 1 | Raster request pulse |
| dma_req | input | 3 | DMA channel request pulses, bit k for channel k |
| m1_n | input | 1 | CPU M1 strobe, active low |
| iorq_n | input | 1 | CPU IORQ strobe, active low |
| dout | output | 8 | Vector driven during acknowledge, zero otherwise |
| dout_oe | output | 1 | Data output enable |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data: enables and write-1-to-clear flags |
| stat_rdata | output | 8 | Status read: enables, serviced bit, DMA flags |
| base_wr | input | 1 | Vector base write strobe |
| base_wdata | input | 8 | Vector base write data |
| int_n | output | 1 | Interrupt request to the CPU, active low |

## Verification
A flag that was not cleared, or was cleared twice, shows up in the vector of the next acknowledge. The raster-then-default pair shows this most plainly, because its second vector changes from 6 to 4. A wrong enable mask or pending bit appears on `int_n` and in `stat_rdata` one clock after the causing write or pulse. A wrong priority or code appears in `dout` one edge after the strobes fall. A latch that is not held shows when the base or a request changes in the middle of a strobe.

// File: rtl/vir_pkg.sv
package vir_pkg;

    typedef enum logic {
        ACK_IDLE = 1'b0,
        ACK_HOLD = 1'b1
    } ack_phase_e;

    // Source code for index idx; idx == n_dma is the raster source.
    function automatic int code_for(input int n_dma, input int idx);
        if (idx >= n_dma)
            return 2 * n_dma;
        return 2 * (n_dma - 1 - idx);
    endfunction

endpackage

// File: rtl/vir_ack_detect.sv
module vir_ack_detect (
    input  logic clk,
    input  logic rst,
    input  logic m1_n,
    input  logic iorq_n,
    output logic ack_start,
    output logic ack_active
);
    import vir_pkg::*;

    ack_phase_e phase_q;
    logic       strobe;

    assign strobe     = ~m1_n & ~iorq_n;
    assign ack_start  = (phase_q == ACK_IDLE) && strobe;
    assign ack_active = (phase_q == ACK_HOLD) && strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ACK_IDLE;
        end else begin
            case (phase_q)
                ACK_IDLE: if (strobe)  phase_q <= ACK_HOLD;
                ACK_HOLD: if (!strobe) phase_q <= ACK_IDLE;
                default:               phase_q <= ACK_IDLE;
            endcase
        end
    end

    // R4: a held strobe never yields a second start
    p_single_start_r4: assert property (@(posedge clk) disable iff (rst)
        ack_start |=> !ack_start);

endmodule

// File: rtl/vir_prio_sel.sv
module vir_prio_sel #(
    parameter int NSRC = 4,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] live,
    output logic            hit,
    output logic [IW-1:0]   idx
);
    // Higher index wins; index 0 is the default when nothing is live.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (live[i]) idx = IW'(i);
        end
        hit = |live;
    end

endmodule

// File: rtl/vir_flags.sv
module vir_flags #(
    parameter int N_DMA = 3,
    localparam int NSRC   = N_DMA + 1,
    localparam int IW     = $clog2(NSRC),
    localparam int STAT_W = 2 * N_DMA + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raster_req,
    input  logic [N_DMA-1:0]  dma_req,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              ack_start,
    input  logic              sel_hit,
    input  logic [IW-1:0]     sel_idx,
    output logic [NSRC-1:0]   pend,
    output logic [NSRC-1:0]   en,
    output logic              log_q
);
    localparam int RASTER = N_DMA;

    logic raster_take;
    assign raster_take = ack_start && sel_hit && (sel_idx == IW'(RASTER));

    for (genvar k = 0; k < N_DMA; k++) begin : g_dma
        always_ff @(posedge clk) begin
            if (rst)
                pend[k] <= 1'b0;
            else if (dma_req[k])
                pend[k] <= 1'b1;
            else if (stat_wr && stat_wdata[k])
                pend[k] <= 1'b0;
        end

        // R9: an acknowledge leaves a DMA flag standing
        p_dma_kept_r9: assert property (@(posedge clk) disable iff (rst)
            ack_start && pend[k] && !(stat_wr && stat_wdata[k]) |=> pend[k]);
        // R11: a request beats a same-cycle clear
        p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
            dma_req[k] |=> pend[k]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend[RASTER] <= 1'b0;
        else if (raster_req)
            pend[RASTER] <= 1'b1;
        else if (raster_take)
            pend[RASTER] <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            log_q <= 1'b0;
        else if (raster_take)
            log_q <= 1'b1;
        else if (stat_wr && stat_wdata[N_DMA])
            log_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (stat_wr)
            en <= stat_wdata[STAT_W-1 -: NSRC];
    end

    // R7: a raster acknowledge clears the flag and logs the service
    p_raster_autoclear_r7: assert property (@(posedge clk) disable iff (rst)
        raster_take && !raster_req |=> !pend[RASTER] && log_q);

endmodule

// File: rtl/vir_vector_out.sv
module vir_vector_out #(
    parameter int N_DMA = 3,
    parameter int VEC_W = 8,
    localparam int NSRC   = N_DMA + 1,
    localparam int IW     = $clog2(NSRC),
    localparam int CODE_W = $clog2(2 * N_DMA + 1),
    localparam int BASE_W = VEC_W - CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             base_wr,
    input  logic [VEC_W-1:0] base_wdata,
    input  logic             ack_start,
    input  logic             ack_active,
    input  logic [IW-1:0]    sel_idx,
    output logic [VEC_W-1:0] dout,
    output logic             dout_oe
);
    import vir_pkg::*;

    logic [BASE_W-1:0] base_q;
    logic [VEC_W-1:0]  vec_q;
    logic [CODE_W-1:0] code_w;

    assign code_w = CODE_W'(code_for(N_DMA, int'(sel_idx)));

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= '0;
        else if (base_wr)
            base_q <= base_wdata[VEC_W-1 -: BASE_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= '0;
        else if (ack_start)
            vec_q <= {base_q, code_w};
    end

    assign dout    = ack_active ? vec_q : '0;
    assign dout_oe = ack_active;

    // R6: the lowest vector bit is never driven high
    p_bit0_zero_r6: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> !dout[0]);
    // R10: the vector holds for the whole strobe
    p_vec_stable_r10: assert property (@(posedge clk) disable iff (rst)
        dout_oe && $past(dout_oe) |-> $stable(dout));

endmodule

// File: rtl/vec_irq_responder.sv
module vec_irq_responder #(
    parameter int N_DMA = 3,
    parameter int VEC_W = 8,
    localparam int NSRC   = N_DMA + 1,
    localparam int IW     = $clog2(NSRC),
    localparam int STAT_W = 2 * N_DMA + 2,
    localparam int CODE_W = $clog2(2 * N_DMA + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raster_req,
    input  logic [N_DMA-1:0]  dma_req,
    input  logic              m1_n,
    input  logic              iorq_n,
    output logic [VEC_W-1:0]  dout,
    output logic              dout_oe,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_rdata,
    input  logic              base_wr,
    input  logic [VEC_W-1:0]  base_wdata,
    output logic              int_n
);
    import vir_pkg::*;

    localparam logic [CODE_W-1:0] DEF_CODE = CODE_W'(code_for(N_DMA, 0));

    logic            ack_start, ack_active;
    logic [NSRC-1:0] pend, en, live;
    logic            log_q, sel_hit;
    logic [IW-1:0]   sel_idx;

    vir_ack_detect u_ack (
        .clk        (clk),
        .rst        (rst),
        .m1_n       (m1_n),
        .iorq_n     (iorq_n),
        .ack_start  (ack_start),
        .ack_active (ack_active)
    );

    vir_flags #(.N_DMA(N_DMA)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .raster_req (raster_req),
        .dma_req    (dma_req),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .ack_start  (ack_start),
        .sel_hit    (sel_hit),
        .sel_idx    (sel_idx),
        .pend       (pend),
        .en         (en),
        .log_q      (log_q)
    );

    assign live = pend & en;

    vir_prio_sel #(.NSRC(NSRC)) u_prio (
        .live (live),
        .hit  (sel_hit),
        .idx  (sel_idx)
    );

    vir_vector_out #(.N_DMA(N_DMA), .VEC_W(VEC_W)) u_vec (
        .clk        (clk),
        .rst        (rst),
        .base_wr    (base_wr),
        .base_wdata (base_wdata),
        .ack_start  (ack_start),
        .ack_active (ack_active),
        .sel_idx    (sel_idx),
        .dout       (dout),
        .dout_oe    (dout_oe)
    );

    assign stat_rdata = {en, log_q, pend[N_DMA-1:0]};
    assign int_n      = ~|live;

    // R5: the chosen source is live and nothing above it is
    p_prio_r5: assert property (@(posedge clk) disable iff (rst)
        sel_hit |-> live[sel_idx] && (((live >> sel_idx) >> 1) == '0));
    // R8: an empty acknowledge falls back to the DMA 0 code
    p_default_r8: assert property (@(posedge clk) disable iff (rst)
        ack_start && !sel_hit |=> !dout_oe || (dout[CODE_W-1:0] == DEF_CODE));

endmodule

// File: tb/vec_irq_responder_test.sv
module vec_irq_responder_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, raster_req, m1_n, iorq_n, stat_wr, base_wr;
    logic [2:0] dma_req;
    logic [7:0] stat_wdata, base_wdata, dout, stat_rdata;
    logic       dout_oe, int_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_irq_responder uut (
        .clk(clk), .rst(rst), .raster_req(raster_req), .dma_req(dma_req),
        .m1_n(m1_n), .iorq_n(iorq_n), .dout(dout), .dout_oe(dout_oe),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
        .base_wr(base_wr), .base_wdata(base_wdata), .int_n(int_n)
    );

    // {req[3:0] raster,dma2,dma1,dma0 ; en[3:0] ; base ; expected vector ; expected status}
    localparam logic [31:0] TBL [8] = '{
        32'h8FAF_AEF8, 32'hFF40_46FF, 32'h7F40_40F7, 32'h37F8_FA73,
        32'h1110_1411, 32'hE320_2236, 32'h0F08_0CF0, 32'h8700_0470
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic stat_write(input logic [7:0] v);
        stat_wr = 1'b1; stat_wdata = v;
        tick();
        stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic base_write(input logic [7:0] v);
        base_wr = 1'b1; base_wdata = v;
        tick();
        base_wr = 1'b0; base_wdata = '0;
    endtask

    task automatic pulse(input logic r, input logic [2:0] d);
        raster_req = r; dma_req = d;
        tick();
        raster_req = 1'b0; dma_req = '0;
    endtask

    task automatic ack_begin();
        m1_n = 1'b0; iorq_n = 1'b0;
        tick();
    endtask

    task automatic ack_end();
        m1_n = 1'b1; iorq_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; raster_req = 1'b0; dma_req = '0; m1_n = 1'b1; iorq_n = 1'b1;
        stat_wr = 1'b0; stat_wdata = '0; base_wr = 1'b0; base_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 stat", stat_rdata, 8'h00);
        chk("R1 int_n", {7'b0, int_n}, 8'h01);
        chk("R1 oe", {7'b0, dout_oe}, 8'h00);

        // Table: R2 R5 R6 R7 R8 R12 under distinct patterns
        for (int i = 0; i < 8; i++) begin
            rst = 1'b1; tick(); rst = 1'b0;
            stat_write({TBL[i][27:24], 4'h0});
            base_write(TBL[i][23:16]);
            pulse(TBL[i][31], TBL[i][30:28]);
            ack_begin();
            chk($sformatf("R5 R6 entry %0d oe", i), {7'b0, dout_oe}, 8'h01);
            chk($sformatf("R5 R6 R8 entry %0d vector", i), dout, TBL[i][15:8]);
            tick();
            chk($sformatf("R4 entry %0d held", i), dout, TBL[i][15:8]);
            ack_end();
            chk($sformatf("R4 entry %0d release", i), {7'b0, dout_oe}, 8'h00);
            chk($sformatf("R2 R7 R9 entry %0d status", i), stat_rdata, TBL[i][7:0]);
        end

        rst = 1'b1; tick(); rst = 1'b0;
        stat_write(8'hF0);

        // R4: M1 low alone is no acknowledge
        pulse(1'b1, 3'b000);
        m1_n = 1'b0;
        tick(); tick();
        chk("R4 m1 alone oe", {7'b0, dout_oe}, 8'h00);
        chk("R4 m1 alone keeps raster", {7'b0, int_n}, 8'h00);
        m1_n = 1'b1;
        tick();

        // R7 R8: raster then immediate second acknowledge
        ack_begin();
        chk("R7 raster vector", dout, 8'h06);
        ack_end();
        chk("R7 raster cleared", {7'b0, int_n}, 8'h01);
        ack_begin();
        chk("R8 second ack default", dout, 8'h04);
        ack_end();
        chk("R7 serviced bit", stat_rdata, 8'hF8);

        // R9: DMA flag survives acknowledge, W1C semantics
        pulse(1'b0, 3'b010);
        ack_begin();
        chk("R9 dma1 vector", dout, 8'h02);
        ack_end();
        chk("R9 dma1 still pending", stat_rdata, 8'hFA);
        stat_write(8'hF0);
        chk("R9 zero write no effect", stat_rdata, 8'hFA);
        stat_write(8'hF2);
        chk("R9 clear dma1", stat_rdata, 8'hF8);
        stat_write(8'hF8);
        chk("R9 clear serviced", stat_rdata, 8'hF0);

        // R3: request line follows pending AND enable
        stat_write(8'h00);
        pulse(1'b0, 3'b001);
        chk("R3 masked", {7'b0, int_n}, 8'h01);
        stat_write(8'h10);
        chk("R3 enabled", {7'b0, int_n}, 8'h00);
        stat_write(8'h11);
        chk("R3 cleared", {7'b0, int_n}, 8'h01);
        chk("R3 status", stat_rdata, 8'h10);

        // R11: request and clear in the same cycle
        stat_write(8'hF0);
        stat_wr = 1'b1; stat_wdata = 8'hF1; dma_req = 3'b001;
        tick();
        stat_wr = 1'b0; stat_wdata = '0; dma_req = '0;
        chk("R11 set wins", stat_rdata, 8'hF1);
        stat_write(8'hF1);

        // R10 R12: changes during the strobe do not disturb the vector
        base_write(8'hAB);
        pulse(1'b0, 3'b100);
        ack_begin();
        chk("R12 base low bits dropped", dout, 8'hA8);
        base_wr = 1'b1; base_wdata = 8'h55; raster_req = 1'b1;
        tick();
        base_wr = 1'b0; base_wdata = '0; raster_req = 1'b0;
        chk("R10 vector held", dout, 8'hA8);
        tick();
        chk("R10 vector still held", dout, 8'hA8);
        ack_end();
        chk("R10 late raster pending", {7'b0, int_n}, 8'h00);
        ack_begin();
        chk("R10 R12 new base and raster", dout, 8'h56);
        ack_end();
        chk("R10 status", stat_rdata, 8'hFC);

        summary();
    end

endmodule